// File: doc/BRIEF.md
# Character Display Instruction and Address Unit

This unit carries out the control instructions of a character display controller against two memories: a display memory of 80 character cells and a glyph memory of 64 bytes. A bus front end decodes the instructions elsewhere and hands this unit one-cycle strobes. The strobes cover clear, return home, entry-mode load and cursor or screen move, together with read and write strobes that say which memory is meant. The unit keeps the address counter, the increment-direction and auto-shift bits, the horizontal screen offset and a busy flag. It drives a single write port toward whichever memory is targeted.

Clear is a sequence that runs over several cycles. It writes the blank code 0x20 into every display cell, one cell per clock, and raises busy for the whole fill. While busy is high, every strobe is dropped. Every memory access moves the address counter one step in the direction set by the increment bit. A display-memory write can also move the screen one column when auto-shift is on. The screen offset wraps within a single line, whose length is 40 columns in two-line mode and 20 in four-line mode. The address counter is linear, so a cursor that leaves the last column of a line lands on the first column of the next line.

Top module: `lcd_instr_unit`

## Requirements
- R1: After reset the address counter and screen offset are 0, the increment bit is 1, the auto-shift bit is 0, busy is 0 and no memory write is driven.
- R2: A clear strobe raises busy from the next cycle for exactly 80 cycles. In each of those cycles it writes 0x20 to one display cell (mem_cg=0), covering cells 0 to 79 once each. It leaves the address counter and offset at 0 and the increment bit at 1, and it keeps the auto-shift bit.
- R3: While busy is 1, every strobe (clear, home, entry, move, read, write) is ignored. No write of the caller's data happens, the fill is not restarted, and the mode bits keep their values.
- R4: Return home sets the address counter and screen offset to 0. It writes no memory and leaves the increment and auto-shift bits as they were.
- R5: An entry-mode strobe loads the increment bit from entry_inc and the auto-shift bit from entry_shift.
- R6: A display-memory write (ram_cg=0) drives mem_we=1, mem_cg=0, mem_addr equal to the address counter and mem_wdata equal to wr_data. The counter then steps +1 when the increment bit is 1 and -1 when it is 0, wrapping 79 to 0 and 0 to 79.
- R7: A glyph-memory access (ram_cg=1) uses the counter modulo 64 as the address, drives mem_cg=1 on writes, and steps the counter modulo 64. It never moves the screen.
- R8: A read strobe steps the address counter like a write, drives no memory write and never moves the screen.
- R9: With auto-shift 1, each display-memory write moves the screen left (offset +1) when the increment bit is 1 and right (offset -1) when it is 0.
- R10: A move strobe with shift_screen=0 steps the cursor, +1 when shift_right=1 and -1 when shift_right=0, modulo 80. With shift_screen=1 it changes only the offset, +1 for a left move and -1 for a right move, and leaves the address counter unchanged.
- R11: The screen offset wraps modulo the line length: 40 when lines4=0 and 20 when lines4=1. A cursor stepping past column 39 (two-line) or 19 (four-line) goes on to address 40 or 20, the first column of the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lines4 | input | 1 | 1 selects four 20-column lines, 0 selects two 40-column lines |
| cmd_clear | input | 1 | Clear strobe |
| cmd_home | input | 1 | Return-home strobe |
| cmd_entry | input | 1 | Entry-mode load strobe |
| entry_inc | input | 1 | Increment bit value for cmd_entry |
| entry_shift | input | 1 | Auto-shift bit value for cmd_entry |
| cmd_shift | input | 1 | Cursor or screen move strobe |
| shift_screen | input | 1 | 1 moves the screen, 0 moves the cursor |
| shift_right | input | 1 | Direction of a move: 1 right, 0 left |
| ram_wr | input | 1 | Memory write strobe |
| ram_rd | input | 1 | Memory read strobe |
| ram_cg | input | 1 | 1 targets glyph memory, 0 display memory |
| wr_data | input | 8 | Data for a memory write |
| mem_we | output | 1 | Memory write enable |
| mem_cg | output | 1 | Write targets glyph memory |
| mem_addr | output | 7 | Write or read address |
| mem_wdata | output | 8 | Write data |
| addr_cnt | output | 7 | Address counter |
| shift_ofs | output | 6 | Screen offset in columns |
| busy | output | 1 | Clear fill in progress |
| inc_mode | output | 1 | Current increment bit |
| shift_mode | output | 1 | Current auto-shift bit |

## Verification
The hardest case to reach from the ports is a strobe arriving during the clear fill. A restarted fill, a stray data write or a mode change would then show up only as one extra busy cycle or one changed byte. The stimulus first sets up a non-default state: auto-shift on, decrement, nonzero offset and counter, and stale bytes in memory. It issues clear and then holds every strobe high, with clashing data, for each cycle that busy is observed. It then requires exactly 80 busy cycles, exactly 80 writes of 0x20, and mode bits that the held entry strobe did not touch. The wrap points are reached by walking the cursor and screen across line ends in both line modes.

// File: rtl/lcdiau_pkg.sv
package lcdiau_pkg;

    localparam int DD_DEPTH_DEF   = 80;
    localparam int CG_DEPTH_DEF   = 64;
    localparam int DATA_W_DEF     = 8;
    localparam int LINE2_LEN_DEF  = 40;
    localparam int LINE4_LEN_DEF  = 20;
    localparam int BLANK_CODE_DEF = 32'h20;

    // Operation chosen for the current cycle, highest priority first.
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_HOME  = 3'd2,
        OP_ENTRY = 3'd3,
        OP_MOVE  = 3'd4,
        OP_WRITE = 3'd5,
        OP_READ  = 3'd6
    } op_e;

    typedef struct packed {
        logic inc;    // 1: step up after access
        logic shift;  // 1: move screen on display write
    } entry_t;

    // One step around a ring of m positions; out-of-ring values re-enter.
    function automatic int unsigned ring_step(input int unsigned n,
                                              input logic up,
                                              input int unsigned m);
        if (up)
            return (n + 1 >= m) ? 0 : n + 1;
        return (n == 0 || n >= m) ? m - 1 : n - 1;
    endfunction

endpackage

// File: rtl/lcdiau_decode.sv
module lcdiau_decode
    import lcdiau_pkg::*;
(
    input  logic busy,
    input  logic cmd_clear,
    input  logic cmd_home,
    input  logic cmd_entry,
    input  logic cmd_shift,
    input  logic ram_wr,
    input  logic ram_rd,
    output op_e  op
);

    always_comb begin
        if (busy)           op = OP_NONE;
        else if (cmd_clear) op = OP_CLEAR;
        else if (cmd_home)  op = OP_HOME;
        else if (cmd_entry) op = OP_ENTRY;
        else if (cmd_shift) op = OP_MOVE;
        else if (ram_wr)    op = OP_WRITE;
        else if (ram_rd)    op = OP_READ;
        else                op = OP_NONE;
    end

endmodule

// File: rtl/lcdiau_clear_seq.sv
module lcdiau_clear_seq #(
    parameter int DEPTH = 80,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic [AW-1:0] fill_addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            fill_addr <= '0;
        end else if (busy) begin
            if (fill_addr == LAST)
                busy <= 1'b0;
            else
                fill_addr <= fill_addr + 1'b1;
        end else if (start) begin
            busy      <= 1'b1;
            fill_addr <= '0;
        end
    end

endmodule

// File: rtl/lcdiau_shift_ofs.sv
module lcdiau_shift_ofs
    import lcdiau_pkg::*;
#(
    parameter int LINE2_LEN = 40,
    parameter int LINE4_LEN = 20,
    parameter int OFS_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lines4,
    input  logic             clr,
    input  logic             step_en,
    input  logic             step_left,
    output logic [OFS_W-1:0] ofs
);

    localparam int unsigned L2 = LINE2_LEN;
    localparam int unsigned L4 = LINE4_LEN;

    int unsigned line_len;

    always_comb line_len = lines4 ? L4 : L2;

    always_ff @(posedge clk) begin
        if (rst || clr)
            ofs <= '0;
        else if (step_en)
            ofs <= OFS_W'(ring_step(32'(ofs), step_left, line_len));
    end

endmodule

// File: rtl/lcd_instr_unit.sv
module lcd_instr_unit
    import lcdiau_pkg::*;
#(
    parameter int DD_DEPTH   = DD_DEPTH_DEF,
    parameter int CG_DEPTH   = CG_DEPTH_DEF,
    parameter int DATA_W     = DATA_W_DEF,
    parameter int LINE2_LEN  = LINE2_LEN_DEF,
    parameter int LINE4_LEN  = LINE4_LEN_DEF,
    parameter int BLANK_CODE = BLANK_CODE_DEF,
    localparam int AC_W      = $clog2(DD_DEPTH),
    localparam int OFS_W     = $clog2(LINE2_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lines4,
    input  logic              cmd_clear,
    input  logic              cmd_home,
    input  logic              cmd_entry,
    input  logic              entry_inc,
    input  logic              entry_shift,
    input  logic              cmd_shift,
    input  logic              shift_screen,
    input  logic              shift_right,
    input  logic              ram_wr,
    input  logic              ram_rd,
    input  logic              ram_cg,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mem_we,
    output logic              mem_cg,
    output logic [AC_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [AC_W-1:0]   addr_cnt,
    output logic [OFS_W-1:0]  shift_ofs,
    output logic              busy,
    output logic              inc_mode,
    output logic              shift_mode
);

    localparam int unsigned DD_N = DD_DEPTH;
    localparam int unsigned CG_N = CG_DEPTH;
    localparam int CG_AW = $clog2(CG_DEPTH);

    op_e             op;
    entry_t          ent;
    logic [AC_W-1:0] ac;
    logic [AC_W-1:0] cg_addr;
    logic [AC_W-1:0] fill_addr;
    logic [AC_W-1:0] access_step;
    logic            ofs_clr;
    logic            ofs_step;
    logic            ofs_left;

    lcdiau_decode u_dec (
        .busy      (busy),
        .cmd_clear (cmd_clear),
        .cmd_home  (cmd_home),
        .cmd_entry (cmd_entry),
        .cmd_shift (cmd_shift),
        .ram_wr    (ram_wr),
        .ram_rd    (ram_rd),
        .op        (op)
    );

    lcdiau_clear_seq #(
        .DEPTH (DD_DEPTH),
        .AW    (AC_W)
    ) u_clr (
        .clk       (clk),
        .rst       (rst),
        .start     (op == OP_CLEAR),
        .busy      (busy),
        .fill_addr (fill_addr)
    );

    // Glyph-memory view of the counter: slice for power-of-two depth.
    generate
        if ((CG_DEPTH & (CG_DEPTH - 1)) == 0) begin : g_cg_pow2
            assign cg_addr = AC_W'(ac[CG_AW-1:0]);
        end else begin : g_cg_mod
            assign cg_addr = AC_W'(32'(ac) % CG_N);
        end
    endgenerate

    // Counter after one read or write access, in the ring of the target memory.
    always_comb begin
        if (ram_cg)
            access_step = AC_W'(ring_step(32'(cg_addr), ent.inc, CG_N));
        else
            access_step = AC_W'(ring_step(32'(ac), ent.inc, DD_N));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ac        <= '0;
            ent.inc   <= 1'b1;
            ent.shift <= 1'b0;
        end else begin
            unique case (op)
                OP_CLEAR: begin
                    ac      <= '0;
                    ent.inc <= 1'b1;
                end
                OP_HOME:  ac <= '0;
                OP_ENTRY: begin
                    ent.inc   <= entry_inc;
                    ent.shift <= entry_shift;
                end
                OP_MOVE: begin
                    if (!shift_screen)
                        ac <= AC_W'(ring_step(32'(ac), shift_right, DD_N));
                end
                OP_WRITE, OP_READ: ac <= access_step;
                default: ;
            endcase
        end
    end

    // Screen offset control.
    always_comb begin
        ofs_clr  = (op == OP_CLEAR) || (op == OP_HOME);
        ofs_step = ((op == OP_WRITE) && !ram_cg && ent.shift) ||
                   ((op == OP_MOVE) && shift_screen);
        ofs_left = (op == OP_WRITE) ? ent.inc : !shift_right;
    end

    lcdiau_shift_ofs #(
        .LINE2_LEN (LINE2_LEN),
        .LINE4_LEN (LINE4_LEN),
        .OFS_W     (OFS_W)
    ) u_ofs (
        .clk       (clk),
        .rst       (rst),
        .lines4    (lines4),
        .clr       (ofs_clr),
        .step_en   (ofs_step),
        .step_left (ofs_left),
        .ofs       (shift_ofs)
    );

    // Memory port: fill has the port to itself while busy.
    always_comb begin
        if (busy) begin
            mem_we    = 1'b1;
            mem_cg    = 1'b0;
            mem_addr  = fill_addr;
            mem_wdata = DATA_W'(BLANK_CODE);
        end else begin
            mem_we    = (op == OP_WRITE);
            mem_cg    = (op == OP_WRITE) && ram_cg;
            mem_addr  = ram_cg ? cg_addr : ac;
            mem_wdata = wr_data;
        end
    end

    assign addr_cnt   = ac;
    assign inc_mode   = ent.inc;
    assign shift_mode = ent.shift;

endmodule

// File: rtl/lcdiau_checker.sv
module lcdiau_checker #(
    parameter int DD_DEPTH   = 80,
    parameter int CG_DEPTH   = 64,
    parameter int DATA_W     = 8,
    parameter int LINE2_LEN  = 40,
    parameter int BLANK_CODE = 32'h20,
    parameter int AC_W       = 7,
    parameter int OFS_W      = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_clear,
    input logic              cmd_home,
    input logic              cmd_entry,
    input logic              entry_inc,
    input logic              entry_shift,
    input logic              cmd_shift,
    input logic              shift_screen,
    input logic              ram_wr,
    input logic              ram_rd,
    input logic              mem_we,
    input logic              mem_cg,
    input logic [AC_W-1:0]   mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [AC_W-1:0]   addr_cnt,
    input logic [OFS_W-1:0]  shift_ofs,
    input logic              busy,
    input logic              inc_mode,
    input logic              shift_mode
);

    logic no_cmd;
    assign no_cmd = !cmd_clear && !cmd_home && !cmd_entry && !cmd_shift;

    AST_CLEAR_STARTS: assert property (@(posedge clk) disable iff (rst)
        (cmd_clear && !busy) |=> busy);  // R2

    AST_FILL_BLANK: assert property (@(posedge clk) disable iff (rst)
        busy |-> (mem_we && !mem_cg && mem_wdata == DATA_W'(BLANK_CODE)));  // R2

    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |-> (addr_cnt == '0 && shift_ofs == '0 && inc_mode));  // R3

    AST_HOME_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cmd_home && !cmd_clear && !busy) |=>
            (addr_cnt == '0 && shift_ofs == '0 && $stable(inc_mode) && $stable(shift_mode)));  // R4

    AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cmd_entry && !cmd_clear && !cmd_home && !busy) |=>
            (inc_mode == $past(entry_inc) && shift_mode == $past(entry_shift)));  // R5

    AST_DD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_cg) |-> (32'(mem_addr) < DD_DEPTH));  // R6

    AST_CG_RANGE: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_cg) |-> (32'(mem_addr) < CG_DEPTH));  // R7

    AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ram_rd && !ram_wr && no_cmd && !busy) |-> !mem_we);  // R8

    AST_READ_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (ram_rd && !ram_wr && no_cmd && !busy) |=> $stable(shift_ofs));  // R8

    AST_SCREEN_KEEPS_AC: assert property (@(posedge clk) disable iff (rst)
        (cmd_shift && shift_screen && !cmd_clear && !cmd_home && !cmd_entry && !busy)
            |=> $stable(addr_cnt));  // R10

    AST_OFS_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(shift_ofs) < LINE2_LEN);  // R11

endmodule

bind lcd_instr_unit lcdiau_checker #(
    .DD_DEPTH   (DD_DEPTH),
    .CG_DEPTH   (CG_DEPTH),
    .DATA_W     (DATA_W),
    .LINE2_LEN  (LINE2_LEN),
    .BLANK_CODE (BLANK_CODE),
    .AC_W       (AC_W),
    .OFS_W      (OFS_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_clear    (cmd_clear),
    .cmd_home     (cmd_home),
    .cmd_entry    (cmd_entry),
    .entry_inc    (entry_inc),
    .entry_shift  (entry_shift),
    .cmd_shift    (cmd_shift),
    .shift_screen (shift_screen),
    .ram_wr       (ram_wr),
    .ram_rd       (ram_rd),
    .mem_we       (mem_we),
    .mem_cg       (mem_cg),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .addr_cnt     (addr_cnt),
    .shift_ofs    (shift_ofs),
    .busy         (busy),
    .inc_mode     (inc_mode),
    .shift_mode   (shift_mode)
);

// File: tb/lcd_instr_unit_test.sv
`timescale 1ns/1ps
module lcd_instr_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lines4 = 1'b0;
    logic       cmd_clear = 1'b0, cmd_home = 1'b0, cmd_entry = 1'b0, cmd_shift = 1'b0;
    logic       entry_inc = 1'b0, entry_shift = 1'b0;
    logic       shift_screen = 1'b0, shift_right = 1'b0;
    logic       ram_wr = 1'b0, ram_rd = 1'b0, ram_cg = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       mem_we, mem_cg, busy, inc_mode, shift_mode;
    logic [6:0] mem_addr, addr_cnt;
    logic [7:0] mem_wdata;
    logic [5:0] shift_ofs;

    int total = 0;
    int bad = 0;
    int dd_writes = 0;
    int cg_writes = 0;
    logic [7:0] dd_model [0:79];
    logic [7:0] cg_model [0:63];

    always #5 clk = ~clk;

    lcd_instr_unit uut (
        .clk(clk), .rst(rst), .lines4(lines4),
        .cmd_clear(cmd_clear), .cmd_home(cmd_home), .cmd_entry(cmd_entry),
        .entry_inc(entry_inc), .entry_shift(entry_shift),
        .cmd_shift(cmd_shift), .shift_screen(shift_screen), .shift_right(shift_right),
        .ram_wr(ram_wr), .ram_rd(ram_rd), .ram_cg(ram_cg), .wr_data(wr_data),
        .mem_we(mem_we), .mem_cg(mem_cg), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .addr_cnt(addr_cnt), .shift_ofs(shift_ofs), .busy(busy),
        .inc_mode(inc_mode), .shift_mode(shift_mode)
    );

    // Memory model fed from the write port, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (mem_cg) begin
                cg_model[mem_addr[5:0]] = mem_wdata;
                cg_writes++;
            end else begin
                if (mem_addr < 7'd80) dd_model[mem_addr] = mem_wdata;
                dd_writes++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_entry(input logic inc, input logic s);
        cmd_entry = 1'b1; entry_inc = inc; entry_shift = s;
        tick();
        cmd_entry = 1'b0;
    endtask

    task automatic do_home();
        cmd_home = 1'b1;
        tick();
        cmd_home = 1'b0;
    endtask

    task automatic do_move(input logic screen, input logic right);
        cmd_shift = 1'b1; shift_screen = screen; shift_right = right;
        tick();
        cmd_shift = 1'b0;
    endtask

    task automatic do_write(input logic cg, input logic [7:0] d);
        ram_wr = 1'b1; ram_cg = cg; wr_data = d;
        tick();
        ram_wr = 1'b0; ram_cg = 1'b0;
    endtask

    task automatic do_read(input logic cg);
        ram_rd = 1'b1; ram_cg = cg;
        tick();
        ram_rd = 1'b0; ram_cg = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 addr", addr_cnt, 0);
        chk("R1 ofs", shift_ofs, 0);
        chk("R1 inc", inc_mode, 1);
        chk("R1 shift", shift_mode, 0);
        chk("R1 busy", busy, 0);
        chk("R1 we", mem_we, 0);
    endtask

    task automatic t_entry();
        do_entry(1'b0, 1'b1);
        chk("R5 inc load 0", inc_mode, 0);
        chk("R5 shift load 1", shift_mode, 1);
        do_entry(1'b1, 1'b0);
        chk("R5 inc load 1", inc_mode, 1);
        chk("R5 shift load 0", shift_mode, 0);
    endtask

    task automatic t_write_wrap();
        int w0;
        lines4 = 1'b0;
        do_home();
        do_entry(1'b0, 1'b0);
        w0 = dd_writes;
        do_write(1'b0, 8'hA1);
        chk("R6 data at 0", dd_model[0], 8'hA1);
        chk("R6 down wrap 0->79", addr_cnt, 79);
        do_write(1'b0, 8'hA2);
        chk("R6 data at 79", dd_model[79], 8'hA2);
        chk("R6 down step", addr_cnt, 78);
        do_entry(1'b1, 1'b0);
        do_write(1'b0, 8'hA3);
        chk("R6 up step", addr_cnt, 79);
        do_write(1'b0, 8'hA4);
        chk("R6 up wrap 79->0", addr_cnt, 0);
        chk("R6 overwrite 79", dd_model[79], 8'hA4);
        chk("R6 write count", dd_writes - w0, 4);
        chk("R6 no shift when S=0", shift_ofs, 0);
    endtask

    task automatic t_line_wrap();
        lines4 = 1'b0;
        do_home();
        for (int i = 0; i < 39; i++) do_move(1'b0, 1'b1);
        chk("R11 cursor at col 39", addr_cnt, 39);
        do_move(1'b0, 1'b1);
        chk("R11 two-line next line", addr_cnt, 40);
        lines4 = 1'b1;
        do_home();
        for (int i = 0; i < 20; i++) do_move(1'b0, 1'b1);
        chk("R11 four-line next line", addr_cnt, 20);
        for (int i = 0; i < 20; i++) do_move(1'b1, 1'b0);
        chk("R11 four-line offset ring", shift_ofs, 0);
        do_move(1'b1, 1'b1);
        chk("R11 four-line right wrap", shift_ofs, 19);
        lines4 = 1'b0;
        do_home();
        do_move(1'b1, 1'b1);
        chk("R11 two-line right wrap", shift_ofs, 39);
        do_move(1'b1, 1'b0);
        chk("R11 two-line left wrap", shift_ofs, 0);
    endtask

    task automatic t_cursor_vs_screen();
        do_home();
        do_move(1'b1, 1'b1);
        chk("R10 screen move keeps addr", addr_cnt, 0);
        chk("R10 screen move offset", shift_ofs, 39);
        do_move(1'b0, 1'b0);
        chk("R10 cursor left wraps", addr_cnt, 79);
        chk("R10 cursor keeps offset", shift_ofs, 39);
    endtask

    task automatic t_shift_write();
        do_home();
        do_entry(1'b1, 1'b1);
        do_write(1'b0, 8'h41);
        chk("R9 left on inc write", shift_ofs, 1);
        chk("R9 addr after inc", addr_cnt, 1);
        do_entry(1'b0, 1'b1);
        do_write(1'b0, 8'h42);
        chk("R9 right on dec write", shift_ofs, 0);
        do_write(1'b0, 8'h43);
        chk("R9 right wraps", shift_ofs, 39);
        chk("R9 addr after dec", addr_cnt, 79);
    endtask

    task automatic t_cg();
        int c0;
        do_home();
        c0 = cg_writes;
        do_write(1'b1, 8'h1F);
        chk("R7 glyph data at 0", cg_model[0], 8'h1F);
        chk("R7 glyph down wrap", addr_cnt, 63);
        chk("R7 no screen move", shift_ofs, 0);
        do_entry(1'b1, 1'b1);
        do_write(1'b1, 8'h0E);
        chk("R7 glyph data at 63", cg_model[63], 8'h0E);
        chk("R7 glyph up wrap", addr_cnt, 0);
        chk("R7 write count", cg_writes - c0, 2);
        chk("R7 still no screen move", shift_ofs, 0);
    endtask

    task automatic t_read();
        int d0, c0;
        do_home();
        d0 = dd_writes; c0 = cg_writes;
        do_read(1'b0);
        chk("R8 read steps addr", addr_cnt, 1);
        chk("R8 read no shift", shift_ofs, 0);
        do_entry(1'b0, 1'b1);
        do_read(1'b0);
        chk("R8 read steps down", addr_cnt, 0);
        do_read(1'b1);
        chk("R8 glyph read steps", addr_cnt, 63);
        chk("R8 read no writes", (dd_writes - d0) + (cg_writes - c0), 0);
    endtask

    task automatic t_home();
        int d0;
        do_home();
        do_entry(1'b0, 1'b1);
        do_write(1'b0, 8'h55);
        d0 = dd_writes;
        do_home();
        chk("R4 addr zero", addr_cnt, 0);
        chk("R4 offset zero", shift_ofs, 0);
        chk("R4 inc kept", inc_mode, 0);
        chk("R4 shift kept", shift_mode, 1);
        chk("R4 no write", dd_writes - d0, 0);
        chk("R4 data kept", dd_model[0], 8'h55);
    endtask

    task automatic t_clear();
        int d0, n, blanks;
        do_entry(1'b0, 1'b1);
        do_move(1'b1, 1'b0);
        do_move(1'b0, 1'b1);
        d0 = dd_writes;
        cmd_clear = 1'b1;
        tick();
        chk("R2 busy after strobe", busy, 1);
        // Hold every strobe with clashing values while the fill runs.
        cmd_home = 1'b1; cmd_entry = 1'b1; entry_inc = 1'b0; entry_shift = 1'b0;
        cmd_shift = 1'b1; shift_screen = 1'b0; ram_wr = 1'b1; ram_rd = 1'b1;
        wr_data = 8'h55;
        n = 0;
        while (busy && n < 200) begin
            n++;
            tick();
        end
        cmd_clear = 1'b0; cmd_home = 1'b0; cmd_entry = 1'b0;
        cmd_shift = 1'b0; ram_wr = 1'b0; ram_rd = 1'b0;
        chk("R2 busy length", n, 80);
        chk("R3 no restart or extra write", dd_writes - d0, 80);
        blanks = 0;
        for (int i = 0; i < 80; i++) if (dd_model[i] == 8'h20) blanks++;
        chk("R2 all cells blank", blanks, 80);
        chk("R2 addr zero", addr_cnt, 0);
        chk("R2 offset zero", shift_ofs, 0);
        chk("R2 inc forced", inc_mode, 1);
        chk("R2 shift kept", shift_mode, 1);
        chk("R3 entry ignored", shift_mode, 1);
        tick();
        chk("R3 idle after fill", mem_we, 0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 80; i++) dd_model[i] = 8'hFF;
        for (int i = 0; i < 64; i++) cg_model[i] = 8'hFF;
        rst = 1'b1;
        tick(); tick(); tick();
        rst = 1'b0;
        t_reset();
        t_entry();
        t_write_wrap();
        t_line_wrap();
        t_cursor_vs_screen();
        t_shift_write();
        t_cg();
        t_read();
        t_home();
        t_clear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule